// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 20-bit virtual page number into a final 32-bit page-table entry. It first looks in a small direct-mapped translation cache. On a miss it reads a directory entry and then a table entry over a single-word memory port with a valid/ready handshake. When a walk finishes it reports the translated entry along with a fault flag and a 3-bit error code. The page-offset bits never enter the block, because translation does not depend on them.

During a walk the block writes back entries whose accessed bit it has set, and sets the dirty bit of the table entry on a write access. The writable and user permissions in the returned entry are the AND of the two levels. A walk that ends in a fault never fills the cache. A flush input clears every cache line in one cycle. The surrounding pipeline presents one request at a time when `req_ready` is high, and takes the result from the single-cycle `rsp_valid` pulse.

Top module: `pgwalk_top`

## Requirements
- R1: The directory entry address is `dir_base + vpn[19:10]*4`. The table entry address is the directory entry's bits 31:12 followed by `vpn[9:0]` and two zero bits.
- R2: The cache is indexed by the low `TLB_IDX_W` bits of the page number and tagged with the rest. On a hit the cached entry is returned one cycle after acceptance, with no memory request.
- R3: If the directory entry or the table entry has bit 0 (present) clear, the response entry is zero, the fault flag is set and the error code is 0. A not-present directory entry ends the walk after one memory access.
- R4: A present directory entry with bit 5 (accessed) clear is written back with bit 5 set before the table entry is read.
- R5: The table entry gets bit 5 set, and also bit 6 (dirty) when the access is a write. It is written back only when its value changed.
- R6: In the returned entry, bit 1 (writable) is the AND of the table and directory bit 1, and bit 2 (user) is the AND of both bit 2 values. All other bits come from the updated table entry.
- R7: A fault is raised when the entry is not present, or bit 2 is clear while the privilege level is nonzero, or the access is a write with write-protect enabled and bit 1 clear.
- R8: The error code is bits 2:0 of the response entry.
- R9: A flush clears every cache line in one cycle. A request accepted in the flush cycle is treated as a miss, and a fill due in the flush cycle is dropped.
- R10: A walk that responds with a fault leaves the cache unchanged for that page.
- R11: A memory request keeps its address, direction and write data stable until `mem_ready`. Memory stalls do not change results.
- R12: After reset the block is idle (`req_ready` high, no memory request, no response). `req_ready` is low from acceptance until the response, and `rsp_valid` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request, taken when `req_ready` is high |
| req_vpn | input | 20 | Virtual page number (address bits 31:12) |
| req_write | input | 1 | Access is a write |
| req_cpl | input | 2 | Current privilege level |
| dir_base | input | 32 | Physical base of the page directory |
| wp_en | input | 1 | Write-protect enforcement enable |
| tlb_flush | input | 1 | Invalidate all cache lines |
| req_ready | output | 1 | Block is idle and can accept a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_entry | output | 32 | Translated entry with merged permissions, zero if not present |
| rsp_fault | output | 1 | Page fault, valid with `rsp_valid` |
| rsp_err | output | 3 | Fault error code, valid with `rsp_valid` |
| mem_valid | output | 1 | Memory request |
| mem_write | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory word address (byte address, word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request; read data is valid in this cycle |
| mem_rdata | input | 32 | Memory read data |

## Verification
Two functions can fall in the same cycle. A cache flush can coincide with the cache lookup at acceptance, or with the cache fill in the response cycle. Both cases are provoked by raising `tlb_flush` together with `req_valid`, and by raising it in the cycle where `rsp_valid` is seen. Each case is then judged by counting memory handshakes on the next request to the same page: a correct design walks again (two accesses) instead of hitting (zero accesses).

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  localparam int WORD_W = 32;
  localparam int VPN_W  = 20;
  localparam int LVL_W  = 10;

  // Entry bit positions
  localparam int B_PRES = 0;
  localparam int B_WR   = 1;
  localparam int B_USR  = 2;
  localparam int B_ACC  = 5;
  localparam int B_DRT  = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_PDE,
    ST_WR_PDE,
    ST_RD_PTE,
    ST_WR_PTE,
    ST_DONE
  } walk_st_t;

  // Directory slot: base plus four bytes per index
  function automatic logic [WORD_W-1:0] dir_slot_addr(input logic [WORD_W-1:0] base,
                                                      input logic [LVL_W-1:0] di);
    return base + {{(WORD_W-LVL_W-2){1'b0}}, di, 2'b00};
  endfunction

  // Table slot: frame of the directory entry, then the table index
  function automatic logic [WORD_W-1:0] tbl_slot_addr(input logic [VPN_W-1:0] frame,
                                                      input logic [LVL_W-1:0] ti);
    return {frame, ti, 2'b00};
  endfunction

  // Accessed always, dirty on a write
  function automatic logic [WORD_W-1:0] leaf_touch(input logic [WORD_W-1:0] e,
                                                   input logic wr);
    logic [WORD_W-1:0] r;
    r = e;
    r[B_ACC] = 1'b1;
    if (wr) r[B_DRT] = 1'b1;
    return r;
  endfunction

  // Both levels must grant a permission
  function automatic logic [WORD_W-1:0] merge_perm(input logic [WORD_W-1:0] leaf,
                                                   input logic dir_wr,
                                                   input logic dir_usr);
    logic [WORD_W-1:0] r;
    r = leaf;
    r[B_WR]  = leaf[B_WR] & dir_wr;
    r[B_USR] = leaf[B_USR] & dir_usr;
    return r;
  endfunction

  function automatic logic access_fault(input logic [2:0] low, input logic wr,
                                        input logic [1:0] cpl, input logic wp);
    return !low[B_PRES] || (!low[B_USR] && (cpl != 2'd0)) || (wr && wp && !low[B_WR]);
  endfunction

endpackage

// File: rtl/pgwalk_tlb.sv
module pgwalk_tlb
  import pgwalk_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic [WORD_W-1:0] lk_entry,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [WORD_W-1:0] fill_entry,
  input  logic              flush
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = VPN_W - IDX_W;

  logic              vld_q [ENTRIES];
  logic [TAG_W-1:0]  tag_q [ENTRIES];
  logic [WORD_W-1:0] dat_q [ENTRIES];

  logic [IDX_W-1:0] lk_idx, fill_idx;
  assign lk_idx   = lk_vpn[IDX_W-1:0];
  assign fill_idx = fill_vpn[IDX_W-1:0];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_line
    logic wr_this;
    assign wr_this = fill_en && !flush && (fill_idx == IDX_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[e] <= 1'b0;
        tag_q[e] <= '0;
        dat_q[e] <= '0;
      end else if (flush) begin
        vld_q[e] <= 1'b0;
      end else if (wr_this) begin
        vld_q[e] <= 1'b1;
        tag_q[e] <= fill_vpn[VPN_W-1:IDX_W];
        dat_q[e] <= fill_entry;
      end
    end
  end

  assign lk_hit   = vld_q[lk_idx] && (tag_q[lk_idx] == lk_vpn[VPN_W-1:IDX_W]);
  assign lk_entry = dat_q[lk_idx];
endmodule

// File: rtl/pgwalk_perm.sv
module pgwalk_perm
  import pgwalk_pkg::*;
(
  input  logic [2:0] ent_low,
  input  logic       wr,
  input  logic [1:0] cpl,
  input  logic       wp,
  output logic       fault,
  output logic [2:0] err
);
  assign fault = access_fault(ent_low, wr, cpl, wp);
  assign err   = ent_low;
endmodule

// File: rtl/pgwalk_fsm.sv
module pgwalk_fsm
  import pgwalk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic              req_write,
  input  logic [1:0]        req_cpl,
  input  logic [WORD_W-1:0] dir_base,
  input  logic              wp_en,
  input  logic              tlb_flush,
  output logic              req_ready,
  input  logic              tlb_hit,
  input  logic [WORD_W-1:0] tlb_entry,
  output logic              fill_en,
  output logic [VPN_W-1:0]  fill_vpn,
  output logic [WORD_W-1:0] ent,
  output logic              walk_wr,
  output logic [1:0]        walk_cpl,
  output logic              walk_wp,
  output logic              rsp_valid,
  input  logic              fault,
  output logic              evt_hit,
  output logic              leaf_wb_phase,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [WORD_W-1:0] mem_rdata
);
  walk_st_t          state;
  logic [VPN_W-1:0]  vpn_q;
  logic [WORD_W-1:0] base_q, pde_q, pte_q, ent_q;
  logic              wr_q, wp_q, hit_q;
  logic [1:0]        cpl_q;
  logic [WORD_W-1:0] pte_next;

  assign pte_next = leaf_touch(mem_rdata, wr_q);
  assign evt_hit  = (state == ST_IDLE) && req_valid && tlb_hit && !tlb_flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      vpn_q  <= '0;
      base_q <= '0;
      pde_q  <= '0;
      pte_q  <= '0;
      ent_q  <= '0;
      wr_q   <= 1'b0;
      wp_q   <= 1'b0;
      hit_q  <= 1'b0;
      cpl_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          vpn_q  <= req_vpn;
          wr_q   <= req_write;
          cpl_q  <= req_cpl;
          wp_q   <= wp_en;
          base_q <= dir_base;
          hit_q  <= evt_hit;
          if (evt_hit) begin
            ent_q <= tlb_entry;
            state <= ST_DONE;
          end else begin
            state <= ST_RD_PDE;
          end
        end
        ST_RD_PDE: if (mem_ready) begin
          pde_q <= mem_rdata | (WORD_W'(1) << B_ACC);
          if (!mem_rdata[B_PRES]) begin
            ent_q <= '0;
            state <= ST_DONE;
          end else if (!mem_rdata[B_ACC]) begin
            state <= ST_WR_PDE;
          end else begin
            state <= ST_RD_PTE;
          end
        end
        ST_WR_PDE: if (mem_ready) state <= ST_RD_PTE;
        ST_RD_PTE: if (mem_ready) begin
          if (!mem_rdata[B_PRES]) begin
            ent_q <= '0;
            state <= ST_DONE;
          end else begin
            pte_q <= pte_next;
            ent_q <= merge_perm(pte_next, pde_q[B_WR], pde_q[B_USR]);
            state <= (pte_next != mem_rdata) ? ST_WR_PTE : ST_DONE;
          end
        end
        ST_WR_PTE: if (mem_ready) state <= ST_DONE;
        ST_DONE:   state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_valid = 1'b0;
    mem_write = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      ST_RD_PDE: begin
        mem_valid = 1'b1;
        mem_addr  = dir_slot_addr(base_q, vpn_q[VPN_W-1:LVL_W]);
      end
      ST_WR_PDE: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_addr  = dir_slot_addr(base_q, vpn_q[VPN_W-1:LVL_W]);
        mem_wdata = pde_q;
      end
      ST_RD_PTE: begin
        mem_valid = 1'b1;
        mem_addr  = tbl_slot_addr(pde_q[WORD_W-1:WORD_W-VPN_W], vpn_q[LVL_W-1:0]);
      end
      ST_WR_PTE: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_addr  = tbl_slot_addr(pde_q[WORD_W-1:WORD_W-VPN_W], vpn_q[LVL_W-1:0]);
        mem_wdata = pte_q;
      end
      default: ;
    endcase
  end

  assign req_ready     = (state == ST_IDLE);
  assign rsp_valid     = (state == ST_DONE);
  assign leaf_wb_phase = (state == ST_WR_PTE);
  assign fill_en       = rsp_valid && !hit_q && !fault && !tlb_flush;
  assign fill_vpn      = vpn_q;
  assign ent           = ent_q;
  assign walk_wr       = wr_q;
  assign walk_cpl      = cpl_q;
  assign walk_wp       = wp_q;
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int TLB_IDX_W = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [19:0] req_vpn,
  input  logic        req_write,
  input  logic [1:0]  req_cpl,
  input  logic [31:0] dir_base,
  input  logic        wp_en,
  input  logic        tlb_flush,
  output logic        req_ready,
  output logic        rsp_valid,
  output logic [31:0] rsp_entry,
  output logic        rsp_fault,
  output logic [2:0]  rsp_err,
  output logic        mem_valid,
  output logic        mem_write,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ready,
  input  logic [31:0] mem_rdata
);
  logic              tlb_hit, evt_fill, evt_hit, leaf_wb_phase;
  logic [WORD_W-1:0] tlb_entry, ent;
  logic [VPN_W-1:0]  fill_vpn;
  logic              walk_wr, walk_wp, perm_fault;
  logic [1:0]        walk_cpl;
  logic [2:0]        perm_err;

  pgwalk_tlb #(.IDX_W(TLB_IDX_W)) tlb_i (
    .clk(clk), .rst_n(rst_n),
    .lk_vpn(req_vpn), .lk_hit(tlb_hit), .lk_entry(tlb_entry),
    .fill_en(evt_fill), .fill_vpn(fill_vpn), .fill_entry(ent),
    .flush(tlb_flush)
  );

  pgwalk_fsm fsm_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vpn(req_vpn), .req_write(req_write),
    .req_cpl(req_cpl), .dir_base(dir_base), .wp_en(wp_en), .tlb_flush(tlb_flush),
    .req_ready(req_ready),
    .tlb_hit(tlb_hit), .tlb_entry(tlb_entry),
    .fill_en(evt_fill), .fill_vpn(fill_vpn),
    .ent(ent), .walk_wr(walk_wr), .walk_cpl(walk_cpl), .walk_wp(walk_wp),
    .rsp_valid(rsp_valid), .fault(perm_fault),
    .evt_hit(evt_hit), .leaf_wb_phase(leaf_wb_phase),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  pgwalk_perm perm_i (
    .ent_low(ent[2:0]), .wr(walk_wr), .cpl(walk_cpl), .wp(walk_wp),
    .fault(perm_fault), .err(perm_err)
  );

  assign rsp_entry = ent;
  assign rsp_fault = rsp_valid && perm_fault;
  assign rsp_err   = perm_err;
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic [31:0] rsp_entry,
  input logic        rsp_fault,
  input logic [2:0]  rsp_err,
  input logic        tlb_flush,
  input logic        mem_valid,
  input logic        mem_write,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ready,
  input logic        evt_hit,
  input logic        evt_fill,
  input logic        leaf_wb_phase,
  input logic        walk_wr,
  input logic        walk_wp
);
  AST_HIT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hit |=> !mem_valid && rsp_valid); // R2
  AST_ABSENT_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_entry[0] |-> rsp_fault && (rsp_err == 3'd0)); // R3
  AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write |-> mem_wdata[5] && mem_wdata[0]); // R4
  AST_WB_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write && leaf_wb_phase && walk_wr |-> mem_wdata[6]); // R5
  AST_WP_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && walk_wr && walk_wp && !rsp_entry[1] |-> rsp_fault); // R7
  AST_FLUSH_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush |-> !evt_fill); // R9
  AST_FAULT_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fill |-> !rsp_fault && rsp_valid); // R10
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write)
                                && $stable(mem_wdata)); // R11
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R12
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_valid) |-> !req_ready); // R12
endmodule

bind pgwalk_top pgwalk_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_entry(rsp_entry), .rsp_fault(rsp_fault), .rsp_err(rsp_err),
  .tlb_flush(tlb_flush), .mem_valid(mem_valid), .mem_write(mem_write),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
  .evt_hit(evt_hit), .evt_fill(evt_fill), .leaf_wb_phase(leaf_wb_phase),
  .walk_wr(walk_wr), .walk_wp(walk_wp)
);

// File: tb/pgwalk_top_tb.sv
module pgwalk_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [19:0] req_vpn = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_cpl = '0;
  logic [31:0] dir_base = 32'h0000_1000;
  logic        wp_en = 1'b0;
  logic        tlb_flush = 1'b0;
  logic        req_ready, rsp_valid, rsp_fault;
  logic [31:0] rsp_entry;
  logic [2:0]  rsp_err;
  logic        mem_valid, mem_write, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #2 clk = ~clk;

  pgwalk_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vpn(req_vpn),
    .req_write(req_write), .req_cpl(req_cpl), .dir_base(dir_base), .wp_en(wp_en),
    .tlb_flush(tlb_flush), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_entry(rsp_entry), .rsp_fault(rsp_fault), .rsp_err(rsp_err),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  // Memory model: 16 KiB of words, images loaded while reset is low
  logic [31:0] mem [4096];
  logic        stall_mode = 1'b0;
  logic        ready_tgl;
  logic [31:0] nacc;
  logic [31:0] hist [8];

  assign mem_ready = !stall_mode || ready_tgl;
  assign mem_rdata = mem[mem_addr[13:2]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4096; i++) mem[i] <= 32'h0;
      mem[32'h1000 >> 2] <= 32'h0000_2007;
      mem[32'h1004 >> 2] <= 32'h0000_3023;
      mem[32'h1008 >> 2] <= 32'h0000_0000;
      mem[32'h100C >> 2] <= 32'h0000_2025;
      mem[32'h2000 >> 2] <= 32'h0005_0007;
      mem[32'h2004 >> 2] <= 32'h0006_0065;
      mem[32'h2008 >> 2] <= 32'h0007_0000;
      mem[32'h200C >> 2] <= 32'h0008_0027;
      mem[32'h3000 >> 2] <= 32'h0009_0027;
      nacc <= 32'd0;
      ready_tgl <= 1'b0;
    end else begin
      ready_tgl <= ~ready_tgl;
      if (mem_valid && mem_ready) begin
        hist[nacc[2:0]] <= mem_addr;
        nacc <= nacc + 32'd1;
        if (mem_write) mem[mem_addr[13:2]] <= mem_wdata;
      end
    end
  end

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog act=%0d exp<=20000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  logic [31:0] r_entry, r_nacc, r_first, r_last;
  logic        r_fault, r_ready;
  logic [2:0]  r_err;

  task automatic run_req(input logic [31:0] va, input logic wr, input logic [1:0] cpl,
                         input logic wp, input logic fl_req, input logic fl_done);
    logic [31:0] start, last;
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_vpn = va[31:12]; req_write = wr;
    req_cpl = cpl; wp_en = wp; tlb_flush = fl_req;
    start = nacc;
    @(negedge clk);
    req_valid = 1'b0; tlb_flush = 1'b0;
    n = 0;
    while (!rsp_valid && n < 300) begin
      @(negedge clk);
      n++;
    end
    if (!rsp_valid) chk("R12 response", 32'd0, 32'd1);
    r_entry = rsp_entry; r_fault = rsp_fault; r_err = rsp_err; r_ready = req_ready;
    r_nacc = nacc - start;
    last = nacc - 32'd1;
    r_first = hist[start[2:0]];
    r_last = hist[last[2:0]];
    if (fl_done) tlb_flush = 1'b1;
    @(negedge clk);
    tlb_flush = 1'b0;
    chk("R12 pulse ends", {31'd0, rsp_valid}, 32'd0);
  endtask

  // {va[31:0], wr, cpl[1:0], wp, fault, err[2:0], accesses[2:0], entry[31:0]}
  localparam logic [74:0] VEC [13] = '{
    {32'h0000_0000, 1'b0, 2'd0, 1'b0, 1'b0, 3'd7, 3'd4, 32'h0005_0027},
    {32'h0000_0123, 1'b1, 2'd3, 1'b1, 1'b0, 3'd7, 3'd0, 32'h0005_0027},
    {32'h0000_1000, 1'b1, 2'd3, 1'b1, 1'b1, 3'd5, 3'd2, 32'h0006_0065},
    {32'h0000_1000, 1'b1, 2'd3, 1'b0, 1'b0, 3'd5, 3'd2, 32'h0006_0065},
    {32'h0000_2000, 1'b0, 2'd0, 1'b0, 1'b1, 3'd0, 3'd2, 32'h0000_0000},
    {32'h0040_0000, 1'b0, 2'd3, 1'b0, 1'b1, 3'd3, 3'd2, 32'h0009_0023},
    {32'h0040_0000, 1'b0, 2'd0, 1'b0, 1'b0, 3'd3, 3'd2, 32'h0009_0023},
    {32'h0080_0000, 1'b0, 2'd0, 1'b0, 1'b1, 3'd0, 3'd1, 32'h0000_0000},
    {32'h0000_3000, 1'b1, 2'd0, 1'b0, 1'b0, 3'd7, 3'd3, 32'h0008_0067},
    {32'h00C0_3000, 1'b0, 2'd0, 1'b1, 1'b0, 3'd5, 3'd2, 32'h0008_0065},
    {32'h00C0_3000, 1'b1, 2'd0, 1'b1, 1'b1, 3'd5, 3'd0, 32'h0008_0065},
    {32'h0000_3000, 1'b0, 2'd0, 1'b0, 1'b0, 3'd7, 3'd2, 32'h0008_0067},
    {32'h0000_0000, 1'b0, 2'd0, 1'b0, 1'b0, 3'd7, 3'd2, 32'h0005_0027}
  };

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    chk("R12 reset req_ready", {31'd0, req_ready}, 32'd1);
    chk("R12 reset mem_valid", {31'd0, mem_valid}, 32'd0);
    chk("R12 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;

    for (int v = 0; v < 13; v++) begin
      logic [74:0] t;
      logic [31:0] va, pde_a;
      t = VEC[v];
      va = t[74:43];
      run_req(va, t[42], t[41:40], t[39], 1'b0, 1'b0);
      chk($sformatf("R6 entry v%0d", v), r_entry, t[31:0]);
      chk($sformatf("R7 fault v%0d", v), {31'd0, r_fault}, {31'd0, t[38]});
      chk($sformatf("R8 err v%0d", v), {29'd0, r_err}, {29'd0, t[37:35]});
      chk($sformatf("R2 R5 accesses v%0d", v), r_nacc, {29'd0, t[34:32]});
      chk($sformatf("R12 busy v%0d", v), {31'd0, r_ready}, 32'd0);
      pde_a = 32'h0000_1000 + {20'd0, va[31:22], 2'b00};
      if (t[34:32] >= 3'd1) chk($sformatf("R1 dir addr v%0d", v), r_first, pde_a);
      if (t[34:32] >= 3'd2)
        chk($sformatf("R1 tbl addr v%0d", v), r_last,
            {mem[pde_a[13:2]][31:12], va[21:12], 2'b00});
    end

    // R4 / R5: entry images after the walks
    chk("R4 dir accessed written", mem[32'h1000 >> 2], 32'h0000_2027);
    chk("R3 absent dir untouched", mem[32'h1008 >> 2], 32'h0000_0000);
    chk("R5 leaf accessed written", mem[32'h2000 >> 2], 32'h0005_0027);
    chk("R5 leaf dirty written", mem[32'h200C >> 2], 32'h0008_0067);
    chk("R5 unchanged leaf", mem[32'h2004 >> 2], 32'h0006_0065);
    chk("R10 absent leaf untouched", mem[32'h2008 >> 2], 32'h0007_0000);

    // R9: flush alone clears a cached page (page 1 is cached)
    @(negedge clk); tlb_flush = 1'b1;
    @(negedge clk); tlb_flush = 1'b0;
    run_req(32'h0000_1000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    chk("R9 flush forces walk", r_nacc, 32'd2);
    run_req(32'h0000_1000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    chk("R2 refilled hit", r_nacc, 32'd0);
    chk("R2 hit entry", r_entry, 32'h0006_0065);

    // R9: flush in the acceptance cycle makes the lookup a miss
    run_req(32'h0000_1000, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0);
    chk("R9 flush with request", r_nacc, 32'd2);

    // R9: flush in the response cycle drops the fill
    run_req(32'h0040_0000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1);
    chk("R9 walk before drop", r_nacc, 32'd2);
    run_req(32'h0040_0000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    chk("R9 dropped fill", r_nacc, 32'd2);
    run_req(32'h0040_0000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    chk("R2 hit after fill", r_nacc, 32'd0);

    // R10: faulting walk then the same page again still walks
    run_req(32'h0000_2000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    run_req(32'h0000_2000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    chk("R10 no fill on fault", r_nacc, 32'd2);

    // R11: stalls leave results unchanged
    stall_mode = 1'b1;
    run_req(32'h0000_3000, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0);
    chk("R11 stalled entry", r_entry, 32'h0008_0067);
    chk("R11 stalled accesses", r_nacc, 32'd2);
    chk("R11 stalled fault", {31'd0, r_fault}, 32'd0);
    stall_mode = 1'b0;

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule